// File: doc/BRIEF.md
# Timestamp Record Queue with Word-Serial Host Readout

This block holds captured precision-time event records for a single port direction until a host collects them. A capture front end presents a whole record in one cycle: a tag word, a 48-bit seconds value, a 32-bit nanoseconds value, a 64-bit source clock identity, a source port number and a sequence id. While timestamping is enabled and space remains, the record is queued.

The host drains the queue through one 16-bit data register. Each read strobe returns the next word of the oldest record, and multi-word fields are returned most significant word first. A status word shows three things: the enable, the word position inside the record being read, and a saturating count of records lost to overflow. A misaligned host sees a nonzero position at a point where it expects to start a new record. A non-empty flag tells the host that at least one complete record is waiting.

Top module: `ts_record_fifo`

## Requirements
- R1: A record offered with `cap_valid` while `ts_en` is high and the queue has room is queued. `not_empty` is high at the second rising edge after the capture edge.
- R2: Each record is read as 12 words in this order: tag; seconds bits 47:32, 31:16, 15:0; nanoseconds bits 31:16, 15:0; clock identity bits 63:48, 47:32, 31:16, 15:0; port number; sequence id. A word appears on `rd_data` in the cycle after its read strobe. The tag is returned unchanged, so its low 3 bits keep the event type code (1 sync, 2 peer-delay request, 3 peer-delay response, 4 delay request).
- R3: `status[12:8]` holds the word position. It is 0 at the start of a record and counts up by one on each read of a non-empty queue. After the 12th word it returns to 0 and the record leaves the queue.
- R4: Records are returned in the order they were captured.
- R5: `status[15]` mirrors `ts_en`. While `ts_en` is low, captures are ignored: nothing is queued and the discard count does not change.
- R6: The queue holds DEPTH (default 90) records. A capture that arrives with `ts_en` high while DEPTH records are held or pending is dropped. Each such drop increments `status[7:4]`, which saturates at 15.
- R7: A read strobe while `not_empty` is low returns 0 on `rd_data` and leaves the word position unchanged.
- R8: A capture in the same cycle as the 12th-word read of a record keeps the occupancy exact. The popped record is gone and the new one is queued.
- R9: After reset, `not_empty`, `rd_data`, the word position and the discard count are 0. Status bits 14:13 and 3:0 always read 0.
- R10: `not_empty` stays high while a record is partly read (nonzero word position).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts_en | input | 1 | Timestamping enable |
| cap_valid | input | 1 | Capture strobe, one record per cycle |
| cap_tag | input | 16 | Tag word, low 3 bits event type |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clk_id | input | 64 | Source clock identity |
| cap_src_port | input | 16 | Source port number |
| cap_seq_id | input | 16 | Sequence id |
| rd_strobe | input | 1 | Host read of the data register |
| rd_data | output | 16 | Word returned by the last read |
| not_empty | output | 1 | At least one complete record queued |
| status | output | 16 | Bit 15 enable, 12:8 word position, 7:4 discard count |

## Verification
An off-by-one in the word position shows on the very next read: that word comes from the wrong field, and `status[12:8]` no longer matches the count the host keeps. A wrong occupancy shows later. `not_empty` may fall while records remain, or stay high after the last one. It may also let an overflow record through, which shifts the discard count and every word after it. Drains after a simultaneous capture-and-pop and after overflow expose both at the end of the queue.

// File: rtl/ts_fifo_pkg.sv
package ts_fifo_pkg;
  localparam int TS_WORD_W = 16;
  localparam int REC_WORDS = 12;

  typedef struct packed {
    logic [15:0] tag;
    logic [47:0] sec;
    logic [31:0] nsec;
    logic [63:0] clk_id;
    logic [15:0] src_port;
    logic [15:0] seq_id;
  } ts_rec_t;

  localparam int REC_W = $bits(ts_rec_t);

  // Word idx of a record, word 0 being the most significant slice.
  function automatic logic [TS_WORD_W-1:0] rec_word(ts_rec_t r, logic [4:0] idx);
    logic [REC_W-1:0] flat;
    flat = r;
    return flat[(REC_W - 1 - TS_WORD_W * int'(idx)) -: TS_WORD_W];
  endfunction
endpackage

// File: rtl/ts_rec_store.sv
module ts_rec_store
  import ts_fifo_pkg::*;
#(
  parameter int DEPTH = 90,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  ts_rec_t       wr_data,
  input  logic [AW-1:0] rd_addr,
  output ts_rec_t       rd_data
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [REC_W-1:0] q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    q <= mem[rd_addr];
  end

  assign rd_data = q;
endmodule

// File: rtl/ts_fifo_ctrl.sv
module ts_fifo_ctrl #(
  parameter int DEPTH  = 90,
  parameter int AW     = $clog2(DEPTH),
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int DROP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_valid,
  input  logic              cap_en,
  input  logic              pop_rec,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  output logic [CW-1:0]     occ,
  output logic              not_empty,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam logic [CW:0] DEPTH_L = (CW+1)'(DEPTH);

  logic [AW-1:0]     head_q, tail_q, head_nx;
  logic [CW-1:0]     occ_q, occ_nx;
  logic              pend_q, ne_q, room, accept, drop_ev;
  logic [CW:0]       fill;
  logic [DROP_W-1:0] drop_q;

  function automatic logic [AW-1:0] step(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    fill    = {1'b0, occ_q} + {{CW{1'b0}}, pend_q};
    room    = fill < DEPTH_L;
    accept  = cap_valid & cap_en & room;
    drop_ev = cap_valid & cap_en & ~room;
    head_nx = pop_rec ? step(head_q) : head_q;
    occ_nx  = occ_q + CW'(pend_q) - CW'(pop_rec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
      pend_q <= 1'b0;
      ne_q   <= 1'b0;
      drop_q <= '0;
    end else begin
      head_q <= head_nx;
      if (accept) tail_q <= step(tail_q);
      pend_q <= accept;
      occ_q  <= occ_nx;
      ne_q   <= occ_nx != '0;
      if (drop_ev && drop_q != '1) drop_q <= drop_q + 1'b1;
    end
  end

  assign wr_en     = accept;
  assign wr_addr   = tail_q;
  assign rd_addr   = head_nx;
  assign occ       = occ_q;
  assign not_empty = ne_q;
  assign drop_cnt  = drop_q;
endmodule

// File: rtl/ts_word_unload.sv
module ts_word_unload
  import ts_fifo_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_strobe,
  input  logic                 not_empty,
  input  ts_rec_t              head_rec,
  output logic [TS_WORD_W-1:0] rd_data,
  output logic [POS_W-1:0]     pos,
  output logic                 pop_rec
);
  logic [POS_W-1:0]     pos_q;
  logic [TS_WORD_W-1:0] data_q;
  logic                 last;

  assign last    = pos_q == POS_W'(REC_WORDS - 1);
  assign pop_rec = rd_strobe & not_empty & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      data_q <= '0;
    end else if (rd_strobe) begin
      if (not_empty) begin
        data_q <= rec_word(head_rec, 5'(pos_q));
        pos_q  <= last ? '0 : pos_q + 1'b1;
      end else begin
        data_q <= '0;
      end
    end
  end

  assign rd_data = data_q;
  assign pos     = pos_q;
endmodule

// File: rtl/ts_record_fifo.sv
module ts_record_fifo
  import ts_fifo_pkg::*;
#(
  parameter int DEPTH  = 90,
  parameter int DROP_W = 4,
  parameter int POS_W  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ts_en,
  input  logic        cap_valid,
  input  logic [15:0] cap_tag,
  input  logic [47:0] cap_sec,
  input  logic [31:0] cap_nsec,
  input  logic [63:0] cap_clk_id,
  input  logic [15:0] cap_src_port,
  input  logic [15:0] cap_seq_id,
  input  logic        rd_strobe,
  output logic [15:0] rd_data,
  output logic        not_empty,
  output logic [15:0] status
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  ts_rec_t           wr_rec, head_rec;
  logic              wr_en, pop_rec;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [CW-1:0]     occ;
  logic [DROP_W-1:0] drop_cnt;
  logic [POS_W-1:0]  pos;

  assign wr_rec = '{tag: cap_tag, sec: cap_sec, nsec: cap_nsec,
                    clk_id: cap_clk_id, src_port: cap_src_port, seq_id: cap_seq_id};

  ts_fifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .DROP_W(DROP_W)) u_ctrl (
    .clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_en(ts_en), .pop_rec(pop_rec),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr), .occ(occ),
    .not_empty(not_empty), .drop_cnt(drop_cnt)
  );

  ts_rec_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_rec),
    .rd_addr(rd_addr), .rd_data(head_rec)
  );

  ts_word_unload #(.POS_W(POS_W)) u_unload (
    .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .not_empty(not_empty),
    .head_rec(head_rec), .rd_data(rd_data), .pos(pos), .pop_rec(pop_rec)
  );

  assign status = {ts_en, 2'b00, pos, drop_cnt, 4'b0000};
endmodule

// File: rtl/ts_record_fifo_chk.sv
module ts_record_fifo_chk #(
  parameter int DEPTH = 90,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          ts_en,
  input logic          rd_strobe,
  input logic          not_empty,
  input logic [15:0]   status,
  input logic [15:0]   rd_data,
  input logic [CW-1:0] occ,
  input logic          wr_en
);
  // R3
  pos_range_chk: assert property (@(posedge clk) disable iff (rst) status[12:8] < 5'd12);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_strobe && !not_empty |=> rd_data == 16'h0 && $stable(status[12:8]));
  // R5
  off_no_write_chk: assert property (@(posedge clk) disable iff (rst) !ts_en |-> !wr_en);
  // R5
  off_drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ts_en |=> $stable(status[7:4]));
  // R6
  drop_sat_chk: assert property (@(posedge clk) disable iff (rst)
    status[7:4] == 4'hF |=> status[7:4] == 4'hF);
  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (rst) occ <= CW'(DEPTH));
  // R10
  mid_record_chk: assert property (@(posedge clk) disable iff (rst)
    status[12:8] != 5'd0 |-> not_empty);
  // R1
  ne_occ_chk: assert property (@(posedge clk) disable iff (rst) not_empty |-> occ != '0);
endmodule

bind ts_record_fifo ts_record_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .ts_en(ts_en), .rd_strobe(rd_strobe), .not_empty(not_empty),
  .status(status), .rd_data(rd_data), .occ(occ), .wr_en(wr_en)
);

// File: tb/ts_record_fifo_tb.sv
module ts_record_fifo_tb;
  localparam int DEPTH = 90;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ts_en = 1'b0, cap_valid = 1'b0, rd_strobe = 1'b0;
  logic [15:0] cap_tag = '0, cap_src_port = '0, cap_seq_id = '0;
  logic [47:0] cap_sec = '0;
  logic [31:0] cap_nsec = '0;
  logic [63:0] cap_clk_id = '0;
  logic [15:0] rd_data, status;
  logic        not_empty;

  int checks = 0, errors = 0;
  int model_occ = 0, model_drop = 0, bpos = 0;
  logic [15:0] exp_words[$];
  logic [15:0] exp_rd[$];
  bit mon_armed = 0;
  string mon_req = "R2";

  always #2.5 clk = ~clk;

  ts_record_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .ts_en(ts_en), .cap_valid(cap_valid), .cap_tag(cap_tag),
    .cap_sec(cap_sec), .cap_nsec(cap_nsec), .cap_clk_id(cap_clk_id),
    .cap_src_port(cap_src_port), .cap_seq_id(cap_seq_id), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .not_empty(not_empty), .status(status)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Monitor: compares each returned word with the scoreboard (R2, R4, R7).
  always @(negedge clk) begin
    if (mon_armed) begin
      logic [15:0] e;
      mon_armed = 0;
      e = exp_rd.pop_front();
      check(rd_data == e, mon_req, rd_data, e);
    end
  end

  // Drive capture signals for record i and update the model.
  task automatic drive_cap(input int i);
    logic [15:0] tg, pn, sq;
    logic [47:0] s;
    logic [31:0] ns;
    logic [63:0] ci;
    tg = 16'((i << 3) | (i % 4 + 1));
    s  = 48'h0A00_0000_0000 + 48'(i * 1234567);
    ns = 32'(i * 7919 + 100);
    ci = 64'hFEDC_BA98_7654_0000 | 64'(i);
    pn = 16'(i + 1);
    sq = 16'(i * 3 + 5);
    cap_valid = 1; cap_tag = tg; cap_sec = s; cap_nsec = ns;
    cap_clk_id = ci; cap_src_port = pn; cap_seq_id = sq;
    if (ts_en) begin
      if (model_occ < DEPTH) begin
        model_occ++;
        exp_words.push_back(tg);
        exp_words.push_back(s[47:32]); exp_words.push_back(s[31:16]); exp_words.push_back(s[15:0]);
        exp_words.push_back(ns[31:16]); exp_words.push_back(ns[15:0]);
        exp_words.push_back(ci[63:48]); exp_words.push_back(ci[47:32]);
        exp_words.push_back(ci[31:16]); exp_words.push_back(ci[15:0]);
        exp_words.push_back(pn); exp_words.push_back(sq);
      end else if (model_drop < 15) model_drop++;
    end
  endtask

  task automatic capture(input int i);
    @(negedge clk);
    drive_cap(i);
    @(posedge clk);
    @(negedge clk);
    cap_valid = 0;
  endtask

  // One host read; optional capture in the same cycle.
  task automatic read_word(input bit with_cap, input int ci);
    bit had;
    @(negedge clk);
    had = not_empty;
    rd_strobe = 1;
    exp_rd.push_back(had ? exp_words.pop_front() : 16'h0);
    mon_req = had ? "R2/R4" : "R7";
    if (with_cap) drive_cap(ci);
    @(posedge clk);
    mon_armed = 1;
    if (had) begin
      bpos++;
      if (bpos == 12) begin bpos = 0; model_occ--; end
    end
    #1 rd_strobe = 0;
    cap_valid = 0;
    @(negedge clk);
    check(status[12:8] == 5'(bpos), "R3", status[12:8], bpos);
    if (bpos != 0) check(not_empty == 1'b1, "R10", not_empty, 1);
  endtask

  task automatic drain(input int n);
    for (int r = 0; r < n; r++)
      for (int w = 0; w < 12; w++) read_word(0, 0);
    @(negedge clk);
    check(not_empty == 1'b0, "R8", not_empty, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R9 reset state
    check(not_empty == 1'b0, "R9", not_empty, 0);
    check(status == 16'h0, "R9", status, 0);
    check(rd_data == 16'h0, "R9", rd_data, 0);
    // R7 empty read
    read_word(0, 0);
    // R5 disabled capture ignored
    capture(500);
    repeat (3) @(negedge clk);
    check(not_empty == 1'b0, "R5", not_empty, 0);
    check(status[7:4] == 4'h0, "R5", status[7:4], 0);
    check(status[15] == 1'b0, "R5", status[15], 0);
    ts_en = 1;
    @(negedge clk);
    check(status[15] == 1'b1, "R5", status[15], 1);
    // R1 capture and non-empty timing
    @(negedge clk);
    drive_cap(1);
    @(posedge clk);
    @(negedge clk) cap_valid = 0;
    check(not_empty == 1'b0, "R1", not_empty, 0);
    @(negedge clk);
    check(not_empty == 1'b1, "R1", not_empty, 1);
    capture(2);
    capture(3);
    repeat (2) @(negedge clk);
    drain(3);
    // R8 capture during final-word pop
    capture(10);
    capture(11);
    repeat (2) @(negedge clk);
    for (int w = 0; w < 11; w++) read_word(0, 0);
    read_word(1, 12);
    repeat (2) @(negedge clk);
    check(not_empty == 1'b1, "R8", not_empty, 1);
    drain(2);
    // R6 overflow with saturating discard count
    for (int i = 0; i < DEPTH; i++) capture(100 + i);
    capture(300);
    @(negedge clk);
    check(status[7:4] == 4'h1, "R6", status[7:4], 1);
    for (int i = 0; i < 16; i++) capture(301 + i);
    @(negedge clk);
    check(status[7:4] == 4'hF, "R6", status[7:4], 15);
    check(model_drop == 15, "R6", model_drop, 15);
    drain(DEPTH);
    read_word(0, 0);
    @(negedge clk);
    check(exp_words.size() == 0, "R4", exp_words.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule